// File: doc/BRIEF.md
# SMM Memory Window Router

This block sits between a memory access path and its possible targets and decides, for every access, whether it lands in system RAM, in PCI/VGA space, or in a black-hole responder that returns all ones. The decision depends on the access address, on whether the requester is in system-management mode (SMM), and on two control bytes. Software loads these bytes through a dword-wide configuration write port. Three address windows are steered: the legacy 128 KB graphics hole at 0xA0000, a 128 KB high alias at 0xFEDA0000 that reaches the same RAM bytes, and a protected segment just below the top of low memory.

The first control byte (the security byte) holds an open bit, a global-enable bit and a write-once lock. The second (the extension byte) holds a high-alias enable and the protected-segment enable and size. Setting the lock forces the open bit to zero and freezes both bytes until reset. Routing is purely combinational from the address, the mode flag and the registered bytes. A configuration write is therefore reflected in the very next cycle.

Top module: `smr_access_router`

## Requirements
- R1: After reset both control bytes read as zero in effect: the low window and the high alias go to PCI for SMM and non-SMM accesses, and addresses below the top of low memory go to RAM.
- R2: The security byte lives at configuration byte offset 0x48 (dword 0x12, byte lane 0) and the extension byte at offset 0x49 (dword 0x12, lane 1). A lane is written only when its byte enable is set and the dword address matches; every other write leaves routing unchanged.
- R3: Security byte bit 6 is open, bit 3 is global enable, bit 4 is lock. Extension byte bit 7 is high enable, bit 0 is segment enable, and bits 2:1 are the segment size code. For non-SMM accesses with open set, the low window goes to RAM when high enable is clear and to PCI when it is set. The high alias goes to RAM only when high enable is set.
- R4: For non-SMM accesses with open clear, the low window goes to PCI and the high alias is not decoded (it goes to PCI like any address above the top of low memory).
- R5: For SMM accesses with global enable set, the low window goes to RAM when high enable is clear, and the high alias goes to RAM when high enable is set. Otherwise SMM accesses follow the non-SMM routing.
- R6: With segment enable set, size code 0 gives 1 MB, 1 gives 2 MB and 2 gives 8 MB. Code 3, or segment enable clear, gives no segment.
- R7: The segment covers [top - size, top). Non-SMM accesses there go to the black hole, and SMM accesses go to RAM.
- R8: A black-hole access is forwarded with its address aligned down to a 4-byte boundary. A high-alias access routed to RAM is forwarded at RAM address (address - 0xFEDA0000 + 0xA0000). Any other access is forwarded unchanged.
- R9: Writing the lock bit clears open in the same write. From then on, writes to either byte are ignored and the lock stays set.
- R10: Reset clears the lock and restores normal writability of both bytes.
- R11: Exactly one target select bit is high at all times: bit 0 RAM, bit 1 PCI, bit 2 black hole.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgDwAddr | input | CFG_DW_AW | Configuration dword address |
| cfgBe | input | 4 | Byte-lane enables of the write |
| cfgWdata | input | 32 | Write data, lane n in bits 8n+7:8n |
| accAddr | input | ADDR_W | Access address |
| accSmm | input | 1 | Access is issued in SMM |
| tgtSel | output | 3 | One-hot target: RAM, PCI, black hole |
| fwdAddr | output | ADDR_W | Address forwarded to the selected target |

## Verification
The router is driven with control-byte combinations that separate every routing term. These are open alone, open with high enable, global enable with and without high enable, and each size code with the segment on and off. Each combination is probed at the first and last byte of every window and one byte outside it, from both modes. This shows whether the low and high windows swap correctly and whether the segment edges are exact. Writes with missing byte enables, a wrong dword, and writes after the lock are each followed by probes that would show any change. These tell a working lock and lane decode apart from ones that leak. A reset after the lock shows the write masks coming back.

// File: rtl/smr_pkg.sv
package smr_pkg;
  // security byte bit positions
  localparam int SEC_OPEN   = 6;
  localparam int SEC_LOCK   = 4;
  localparam int SEC_GLOBAL = 3;
  // extension byte bit positions
  localparam int EXT_HIGH   = 7;
  localparam int EXT_SZ_LSB = 1;
  localparam int EXT_SEG_EN = 0;

  localparam logic [7:0] SEC_MASK_NORMAL = 8'h58;
  localparam logic [7:0] SEC_MASK_LOCKED = 8'h00;
  localparam logic [7:0] EXT_MASK_NORMAL = 8'h87;
  localparam logic [7:0] EXT_MASK_LOCKED = 8'h00;
  localparam logic [7:0] SEC_RESET       = 8'h00;
  localparam logic [7:0] EXT_RESET       = 8'h00;

  localparam logic [2:0] SEL_RAM  = 3'b001;
  localparam logic [2:0] SEL_PCI  = 3'b010;
  localparam logic [2:0] SEL_HOLE = 3'b100;

  // strobes from the control stage to the route datapath
  typedef struct packed {
    logic       openEn;
    logic       globalEn;
    logic       highEn;
    logic       segOn;
    logic [1:0] segCode;
  } ctrl_s;
endpackage

// File: rtl/smr_cfg_ctrl.sv
module smr_cfg_ctrl
  import smr_pkg::*;
#(
  parameter int                 CFG_DW_AW = 6,
  parameter logic [CFG_DW_AW+1:0] SEC_OFS = 8'h48,
  parameter logic [CFG_DW_AW+1:0] EXT_OFS = 8'h49
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgWe,
  input  logic [CFG_DW_AW-1:0] cfgDwAddr,
  input  logic [3:0]           cfgBe,
  input  logic [31:0]          cfgWdata,
  output ctrl_s                ctrlOut,
  output logic                 lockedOut
);
  localparam int NBYTE = 2;

  logic [7:0] regQ   [NBYTE];
  logic [7:0] regD   [NBYTE];
  logic [7:0] laneDat[NBYTE];
  logic       laneHit[NBYTE];
  logic [7:0] wrMask [NBYTE];
  logic       lockNow;

  assign lockNow = regQ[0][SEC_LOCK];

  genvar g;
  generate
    for (g = 0; g < NBYTE; g++) begin : gByte
      localparam logic [CFG_DW_AW+1:0] OFS = (g == 0) ? SEC_OFS : EXT_OFS;
      localparam int LANE = int'(OFS[1:0]);
      localparam logic [7:0] MASK_N = (g == 0) ? SEC_MASK_NORMAL : EXT_MASK_NORMAL;
      localparam logic [7:0] MASK_L = (g == 0) ? SEC_MASK_LOCKED : EXT_MASK_LOCKED;
      localparam logic [7:0] RST_V  = (g == 0) ? SEC_RESET : EXT_RESET;

      assign laneHit[g] = cfgWe && (cfgDwAddr == OFS[CFG_DW_AW+1:2]) && cfgBe[LANE];
      assign laneDat[g] = cfgWdata[8*LANE +: 8];
      assign wrMask[g]  = lockNow ? MASK_L : MASK_N;

      always_ff @(posedge clk) begin
        if (!rstN) regQ[g] <= RST_V;
        else       regQ[g] <= regD[g];
      end
    end
  endgenerate

  always_comb begin
    for (int i = 0; i < NBYTE; i++) begin
      regD[i] = laneHit[i] ? ((regQ[i] & ~wrMask[i]) | (laneDat[i] & wrMask[i]))
                           : regQ[i];
    end
    // a set lock always wins over open
    if (regD[0][SEC_LOCK]) regD[0][SEC_OPEN] = 1'b0;
  end

  assign ctrlOut.openEn   = regQ[0][SEC_OPEN];
  assign ctrlOut.globalEn = regQ[0][SEC_GLOBAL];
  assign ctrlOut.highEn   = regQ[1][EXT_HIGH];
  assign ctrlOut.segOn    = regQ[1][EXT_SEG_EN];
  assign ctrlOut.segCode  = regQ[1][EXT_SZ_LSB +: 2];
  assign lockedOut        = lockNow;
endmodule

// File: rtl/smr_route_dp.sv
module smr_route_dp
  import smr_pkg::*;
#(
  parameter int                ADDR_W = 32,
  parameter logic [ADDR_W-1:0] TOP    = 32'h8000_0000
) (
  input  logic [ADDR_W-1:0] accAddr,
  input  logic              accSmm,
  input  ctrl_s             ctrl,
  output logic [2:0]        tgtSel,
  output logic [ADDR_W-1:0] fwdAddr
);
  localparam logic [ADDR_W-1:0] LOW_BASE  = ADDR_W'(32'h000A_0000);
  localparam logic [ADDR_W-1:0] WIN_SIZE  = ADDR_W'(32'h0002_0000);
  localparam logic [ADDR_W-1:0] HIGH_BASE = ADDR_W'(32'hFEDA_0000);
  localparam logic [ADDR_W-1:0] LOW_END   = LOW_BASE + WIN_SIZE;
  localparam logic [ADDR_W-1:0] HIGH_END  = HIGH_BASE + WIN_SIZE;
  localparam logic [ADDR_W-1:0] ALIAS_OFS = HIGH_BASE - LOW_BASE;

  logic [ADDR_W-1:0] segBytes;
  logic [ADDR_W-1:0] segBase;
  logic inSeg, inLow, inHigh, lowRam, highRam, smmWin;

  always_comb begin
    segBytes = '0;
    if (ctrl.segOn) begin
      unique case (ctrl.segCode)
        2'd0:    segBytes = ADDR_W'(32'h0010_0000);
        2'd1:    segBytes = ADDR_W'(32'h0020_0000);
        2'd2:    segBytes = ADDR_W'(32'h0080_0000);
        default: segBytes = '0;
      endcase
    end
  end

  assign segBase = TOP - segBytes;
  assign inSeg   = (segBytes != '0) && (accAddr >= segBase) && (accAddr < TOP);
  assign inLow   = (accAddr >= LOW_BASE) && (accAddr < LOW_END);
  assign inHigh  = (accAddr >= HIGH_BASE) && (accAddr < HIGH_END);

  // SMM view overlays the normal view only where global enable maps it
  assign smmWin  = accSmm && ctrl.globalEn;
  assign lowRam  = (smmWin && !ctrl.highEn) || (ctrl.openEn && !ctrl.highEn);
  assign highRam = (smmWin && ctrl.highEn)  || (ctrl.openEn && ctrl.highEn);

  always_comb begin
    fwdAddr = accAddr;
    if (inSeg) begin
      if (accSmm) begin
        tgtSel = SEL_RAM;
      end else begin
        tgtSel = SEL_HOLE;
        fwdAddr = {accAddr[ADDR_W-1:2], 2'b00};
      end
    end else if (inLow) begin
      tgtSel = lowRam ? SEL_RAM : SEL_PCI;
    end else if (inHigh && highRam) begin
      tgtSel = SEL_RAM;
      fwdAddr = accAddr - ALIAS_OFS;
    end else begin
      tgtSel = (accAddr < TOP) ? SEL_RAM : SEL_PCI;
    end
  end
endmodule

// File: rtl/smr_access_router.sv
module smr_access_router
  import smr_pkg::*;
#(
  parameter int                    ADDR_W      = 32,
  parameter logic [ADDR_W-1:0]     BELOW4G_TOP = 32'h8000_0000,
  parameter int                    CFG_DW_AW   = 6,
  parameter logic [CFG_DW_AW+1:0]  SEC_OFS     = 8'h48,
  parameter logic [CFG_DW_AW+1:0]  EXT_OFS     = 8'h49
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgWe,
  input  logic [CFG_DW_AW-1:0] cfgDwAddr,
  input  logic [3:0]           cfgBe,
  input  logic [31:0]          cfgWdata,
  input  logic [ADDR_W-1:0]    accAddr,
  input  logic                 accSmm,
  output logic [2:0]           tgtSel,
  output logic [ADDR_W-1:0]    fwdAddr
);
  ctrl_s ctrlBus;
  logic  lockedQ;

  smr_cfg_ctrl #(
    .CFG_DW_AW(CFG_DW_AW), .SEC_OFS(SEC_OFS), .EXT_OFS(EXT_OFS)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgDwAddr(cfgDwAddr),
    .cfgBe(cfgBe), .cfgWdata(cfgWdata), .ctrlOut(ctrlBus), .lockedOut(lockedQ)
  );

  smr_route_dp #(
    .ADDR_W(ADDR_W), .TOP(BELOW4G_TOP)
  ) uRoute (
    .accAddr(accAddr), .accSmm(accSmm), .ctrl(ctrlBus),
    .tgtSel(tgtSel), .fwdAddr(fwdAddr)
  );
endmodule

// File: rtl/smr_router_chk.sv
module smr_router_chk
  import smr_pkg::*;
#(
  parameter int                ADDR_W = 32,
  parameter logic [ADDR_W-1:0] TOP    = 32'h8000_0000
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] accAddr,
  input logic              accSmm,
  input logic [2:0]        tgtSel,
  input ctrl_s             ctrl,
  input logic              locked
);
  logic [ADDR_W-1:0] segSz;
  logic              segHit;

  always_comb begin
    segSz = '0;
    if (ctrl.segOn && ctrl.segCode != 2'd3)
      segSz = ADDR_W'(32'h0010_0000) << ((ctrl.segCode == 2'd2) ? 3 : int'(ctrl.segCode));
  end
  assign segHit = (segSz != '0) && (accAddr < TOP) && (accAddr >= TOP - segSz);

  assert_one_target_R11: assert property (@(posedge clk) disable iff (!rstN)
    $countones(tgtSel) == 1);

  assert_lock_kills_open_R9: assert property (@(posedge clk) disable iff (!rstN)
    locked |-> !ctrl.openEn);

  assert_lock_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    locked |=> locked);

  assert_lock_freezes_R9: assert property (@(posedge clk) disable iff (!rstN)
    locked |=> ($stable(ctrl.globalEn) && $stable(ctrl.highEn) &&
                $stable(ctrl.segOn) && $stable(ctrl.segCode)));

  assert_hole_only_nonsmm_R7: assert property (@(posedge clk) disable iff (!rstN)
    (tgtSel == SEL_HOLE) |-> !accSmm);

  assert_segment_guarded_R7: assert property (@(posedge clk) disable iff (!rstN)
    (segHit && !accSmm) |-> (tgtSel == SEL_HOLE));

  assert_segment_smm_ram_R7: assert property (@(posedge clk) disable iff (!rstN)
    (segHit && accSmm) |-> (tgtSel == SEL_RAM));
endmodule

bind smr_access_router smr_router_chk #(.ADDR_W(ADDR_W), .TOP(BELOW4G_TOP)) uChk (
  .clk(clk), .rstN(rstN), .accAddr(accAddr), .accSmm(accSmm),
  .tgtSel(tgtSel), .ctrl(ctrlBus), .locked(lockedQ)
);

// File: tb/sim_smr_access_router.sv
`timescale 1ns/1ps
module sim_smr_access_router;
  localparam logic [31:0] TOP = 32'h8000_0000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [5:0]  cfgDwAddr = '0;
  logic [3:0]  cfgBe = '0;
  logic [31:0] cfgWdata = '0;
  logic [31:0] accAddr = '0;
  logic        accSmm = 1'b0;
  logic [2:0]  tgtSel;
  logic [31:0] fwdAddr;

  int vectors = 0;
  int miscompares = 0;

  // reference state: the two control bytes as software would see them
  logic [7:0] mSec = 8'h00;
  logic [7:0] mExt = 8'h00;

  always #2.5 clk = ~clk;

  smr_access_router u0 (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgDwAddr(cfgDwAddr),
    .cfgBe(cfgBe), .cfgWdata(cfgWdata), .accAddr(accAddr), .accSmm(accSmm),
    .tgtSel(tgtSel), .fwdAddr(fwdAddr)
  );

  function automatic int unsigned segSize();
    if (!mExt[0]) return 0;
    case (mExt[2:1])
      2'd0: return 32'h0010_0000;
      2'd1: return 32'h0020_0000;
      2'd2: return 32'h0080_0000;
      default: return 0;
    endcase
  endfunction

  task automatic predict(input logic [31:0] a, input bit smm,
                         output logic [2:0] t, output logic [31:0] f);
    int unsigned sz = segSize();
    bit op = mSec[6], ge = mSec[3], he = mExt[7];
    bit lowMapped  = (op && !he) || (smm && ge && !he);
    bit highMapped = (op && he) || (smm && ge && he);
    f = a;
    if (sz != 0 && a < TOP && a >= TOP - sz) begin
      t = smm ? 3'b001 : 3'b100;
      if (!smm) f = a & 32'hFFFF_FFFC;
    end else if (a >= 32'h000A_0000 && a <= 32'h000B_FFFF) begin
      t = lowMapped ? 3'b001 : 3'b010;
    end else if (a >= 32'hFEDA_0000 && a <= 32'hFEDB_FFFF && highMapped) begin
      t = 3'b001;
      f = a - 32'hFED0_0000;
    end else begin
      t = (a < TOP) ? 3'b001 : 3'b010;
    end
  endtask

  task automatic check(input logic [31:0] a, input bit smm, input string req);
    logic [2:0] et;
    logic [31:0] ef;
    @(negedge clk);
    accAddr = a;
    accSmm  = smm;
    #1;
    predict(a, smm, et, ef);
    vectors++;
    if (tgtSel !== et || fwdAddr !== ef) begin
      miscompares++;
      $display("FAIL %s addr=%h smm=%0d: got sel=%b fwd=%h, expected sel=%b fwd=%h",
               req, a, smm, tgtSel, fwdAddr, et, ef);
    end
  endtask

  task automatic cfgWrite(input logic [5:0] dw, input logic [3:0] be, input logic [31:0] d);
    bit wasLocked = mSec[4];
    logic [7:0] sm = wasLocked ? 8'h00 : 8'h58;
    logic [7:0] em = wasLocked ? 8'h00 : 8'h87;
    @(negedge clk);
    cfgWe = 1'b1; cfgDwAddr = dw; cfgBe = be; cfgWdata = d;
    @(negedge clk);
    cfgWe = 1'b0; cfgBe = '0;
    if (dw == 6'h12 && be[0]) mSec = (mSec & ~sm) | (d[7:0] & sm);
    if (dw == 6'h12 && be[1]) mExt = (mExt & ~em) | (d[15:8] & em);
    if (mSec[4]) mSec[6] = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    mSec = 8'h00;
    mExt = 8'h00;
  endtask

  task automatic sweepWindows(input string req);
    logic [31:0] pts[10] = '{32'h0009_FFFF, 32'h000A_0000, 32'h000B_FFFF, 32'h000C_0000,
                             32'hFED9_FFFF, 32'hFEDA_0000, 32'hFEDB_FFFF, 32'hFEDC_0000,
                             32'h0000_1000, 32'h7FFF_FFFF};
    foreach (pts[i]) begin
      check(pts[i], 1'b0, req);
      check(pts[i], 1'b1, req);
    end
  endtask

  task automatic segEdges(input string req);
    int unsigned sz = segSize();
    logic [31:0] b = TOP - ((sz == 0) ? 32'h0080_0000 : sz);
    check(b - 1, 1'b0, req);
    check(b, 1'b0, req);
    check(b + 3, 1'b0, req);
    check(b + 3, 1'b1, req);
    check(TOP - 1, 1'b0, req);
    check(TOP - 2, 1'b1, req);
    check(TOP, 1'b0, req);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    doReset();
    // R1: defaults after reset
    sweepWindows("R1 reset routing");

    // R2: missing byte enable and wrong dword are ignored
    cfgWrite(6'h12, 4'b0000, 32'h0000_8048);
    sweepWindows("R2 no byte enable");
    cfgWrite(6'h13, 4'b1111, 32'hFFFF_FFFF);
    sweepWindows("R2 wrong dword");
    cfgWrite(6'h12, 4'b1100, 32'hFFFF_FFFF);
    sweepWindows("R2 other lanes");

    // R3: open alone, then open with high enable (R8 alias remap)
    cfgWrite(6'h12, 4'b0001, 32'h0000_0040);
    sweepWindows("R3 open low to RAM");
    cfgWrite(6'h12, 4'b0010, 32'h0000_8000);
    sweepWindows("R3 R8 open high alias");
    check(32'hFEDA_1234, 1'b0, "R8 alias address");

    // R4 and R5: open clear, global enable with high enable set then clear
    cfgWrite(6'h12, 4'b0011, 32'h0000_8008);
    sweepWindows("R4 R5 global high");
    cfgWrite(6'h12, 4'b0010, 32'h0000_0000);
    sweepWindows("R4 R5 global low");
    cfgWrite(6'h12, 4'b0001, 32'h0000_0000);
    sweepWindows("R4 closed");

    // R6 R7 R8: every size code with segment on, and a code with segment off
    for (int c = 0; c < 4; c++) begin
      cfgWrite(6'h12, 4'b0010, {16'h0, 8'((c << 1) | 1), 8'h00});
      segEdges("R6 R7 R8 segment");
    end
    cfgWrite(6'h12, 4'b0010, 32'h0000_0400);
    segEdges("R6 segment disabled");

    // R9: lock clears open in the same write and freezes both bytes
    cfgWrite(6'h12, 4'b0011, 32'h0000_0048);
    cfgWrite(6'h12, 4'b0001, 32'h0000_0058);
    sweepWindows("R9 lock clears open");
    cfgWrite(6'h12, 4'b0011, 32'h0000_8740);
    sweepWindows("R9 writes ignored");
    segEdges("R9 segment frozen");
    cfgWrite(6'h12, 4'b0001, 32'h0000_0000);
    sweepWindows("R9 lock stays");

    // R10: reset restores writability
    doReset();
    sweepWindows("R10 after reset");
    cfgWrite(6'h12, 4'b0011, 32'h0000_8040);
    sweepWindows("R10 writable again");

    // R11: one-hot select is compared within every vector above
    check(32'hFFFF_FFFF, 1'b1, "R11 top of space");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule